// File: doc/BRIEF.md
# Lockable Access-Protection Configuration Registers

This block holds the access policy for a guarded external-memory region. Two protection bits decide whether CPU write accesses and CPU instruction fetches to that region are allowed. Software programs them through a small register port with a privileged-write qualifier. Every cycle, the block answers two access-check inputs with allow outputs and, for a refused attempt, a one-cycle violation pulse.

The protection bits can be frozen at two levels. The first is a lock bit that software may set and clear again. The second is a commit bit that can only be set, and is cleared only by reset. While either level is active, writes to the protection bits are dropped. Writes to the commit and protection registers also need the privileged-write qualifier. The lock register does not.

Top module: `prot_cfg_regs`

## Requirements
- R1: After reset, all three registers read 0, `wr_allow` and `fetch_allow` are 1, both violation pulses are 0 and `reg_rdata` is 0.
- R2: The lock register sits at offset 0x0 and its bit 0 is read/write. It is written with or without `priv_wr`.
- R3: While the lock bit is 1, writes to the protection register (offset 0x8) are dropped. While it is 0 and the commit bit is 0, privileged writes to it take effect.
- R4: The commit register sits at offset 0x2. A privileged write with data bit 0 = 1 sets it. Writing 0, or writing 1 again, has no effect. Only reset clears it.
- R5: While the commit bit is 1, writes to the protection register are dropped, whatever value the lock bit holds.
- R6: A write to the commit or protection register with `priv_wr` = 0 changes nothing.
- R7: Protection register bit 1 is the write block: when it is 1, `wr_allow` is 0. Bit 0 is the fetch block: when it is 1, `fetch_allow` is 0. Both outputs follow the stored bits combinationally.
- R8: A write attempt (`cpu_wr_try`) or fetch attempt (`cpu_fetch_try`) made while the matching block bit is 1 raises `viol_wr` or `viol_fetch`, respectively, for exactly the next cycle. Allowed attempts raise no pulse.
- R9: Writes to any offset other than 0x0, 0x2 and 0x8 are ignored, and reads from them return 0. Unimplemented upper bits of every register read 0.
- R10: A read issued in one cycle presents its data on `reg_rdata` in the next cycle. In a cycle that follows no read, `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| priv_wr | input | 1 | Privileged-write qualifier |
| reg_rdata | output | DATA_W | Registered read data |
| cpu_wr_try | input | 1 | CPU write attempt to the guarded region |
| cpu_fetch_try | input | 1 | CPU fetch attempt from the guarded region |
| wr_allow | output | 1 | CPU writes allowed |
| fetch_allow | output | 1 | CPU fetches allowed |
| viol_wr | output | 1 | One-cycle pulse after a refused write |
| viol_fetch | output | 1 | One-cycle pulse after a refused fetch |

## Verification
The bench builds the block with its default parameters: a 4-bit offset and a 32-bit data bus. These defaults reach every decoded offset plus reserved offsets on both sides of them (0x4 and 0xF), and let all-ones write data test that upper bits read 0. The sequence covers each freezing level on its own, then the two levels together, then a mid-run reset that releases the commit bit. A scoreboard checks every read against the register contents the requirements predict.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_FETCH = 0;
  localparam int unsigned CH_WR    = 1;
endpackage

// File: rtl/pcr_freeze.sv
module pcr_freeze #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LOCK_OFS   = 0,
  parameter int unsigned COMMIT_OFS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              priv,
  output logic [DATA_W-1:0] lock_word,
  output logic [DATA_W-1:0] commit_word,
  output logic              fields_open
);
  localparam logic [DATA_W-1:0] BIT0_MASK = DATA_W'(1);

  logic hit_lock, hit_commit;
  assign hit_lock   = wr_en && (addr == ADDR_W'(LOCK_OFS));
  assign hit_commit = wr_en && priv && (addr == ADDR_W'(COMMIT_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_word <= '0;
    end else if (hit_lock) begin
      lock_word <= wdata & BIT0_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_word <= '0;
    end else if (hit_commit) begin
      commit_word <= commit_word | (wdata & BIT0_MASK);
    end
  end

  assign fields_open = !lock_word[0] && !commit_word[0];

  AST_COMMIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    commit_word[0] |=> commit_word[0]); // R4
  AST_COMMIT_NEEDS_PRIV: assert property (@(posedge clk) disable iff (rst)
    (!commit_word[0] && !priv) |=> !commit_word[0]); // R6
endmodule

// File: rtl/pcr_fields.sv
module pcr_fields #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PROT_OFS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              priv,
  input  logic              fields_open,
  output logic [DATA_W-1:0] prot_word
);
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(3);

  logic take;
  assign take = wr_en && priv && fields_open && (addr == ADDR_W'(PROT_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_word <= '0;
    end else if (take) begin
      prot_word <= wdata & FIELD_MASK;
    end
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fields_open |=> $stable(prot_word)); // R3
  AST_NOPRIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !priv |=> $stable(prot_word)); // R6
endmodule

// File: rtl/pcr_gate.sv
module pcr_gate #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] try_i,
  input  logic [NCH-1:0] blk_i,
  output logic [NCH-1:0] allow_o,
  output logic [NCH-1:0] viol_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign allow_o[c] = !blk_i[c];

    always_ff @(posedge clk) begin
      if (rst) viol_o[c] <= 1'b0;
      else     viol_o[c] <= try_i[c] && blk_i[c];
    end

    AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (rst)
      viol_o[c] |-> ($past(try_i[c]) && $past(blk_i[c]))); // R8
    AST_VIOL_ONE: assert property (@(posedge clk) disable iff (rst)
      (try_i[c] && blk_i[c]) |=> viol_o[c]); // R8
  end
endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
  import prot_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LOCK_OFS   = 0,
  parameter int unsigned COMMIT_OFS = 2,
  parameter int unsigned PROT_OFS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              priv_wr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_wr_try,
  input  logic              cpu_fetch_try,
  output logic              wr_allow,
  output logic              fetch_allow,
  output logic              viol_wr,
  output logic              viol_fetch
);
  logic [DATA_W-1:0] lock_word, commit_word, prot_word;
  logic              fields_open;
  logic [NUM_CH-1:0] try_v, blk_v, allow_v, viol_v;

  pcr_freeze #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOCK_OFS(LOCK_OFS), .COMMIT_OFS(COMMIT_OFS)
  ) u_freeze (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .priv(priv_wr),
    .lock_word(lock_word), .commit_word(commit_word),
    .fields_open(fields_open)
  );

  pcr_fields #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_OFS(PROT_OFS)
  ) u_fields (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .priv(priv_wr), .fields_open(fields_open),
    .prot_word(prot_word)
  );

  assign try_v[CH_WR]    = cpu_wr_try;
  assign try_v[CH_FETCH] = cpu_fetch_try;
  assign blk_v[CH_WR]    = prot_word[1];
  assign blk_v[CH_FETCH] = prot_word[0];

  pcr_gate #(.NCH(NUM_CH)) u_gate (
    .clk(clk), .rst(rst), .try_i(try_v), .blk_i(blk_v),
    .allow_o(allow_v), .viol_o(viol_v)
  );

  assign wr_allow    = allow_v[CH_WR];
  assign fetch_allow = allow_v[CH_FETCH];
  assign viol_wr     = viol_v[CH_WR];
  assign viol_fetch  = viol_v[CH_FETCH];

  logic [DATA_W-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    if (reg_addr == ADDR_W'(LOCK_OFS))        rd_sel = lock_word;
    else if (reg_addr == ADDR_W'(COMMIT_OFS)) rd_sel = commit_word;
    else if (reg_addr == ADDR_W'(PROT_OFS))   rd_sel = prot_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_sel;
    else             reg_rdata <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0)); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:2] == '0); // R9
endmodule

// File: tb/tb_prot_cfg_regs.sv
module tb_prot_cfg_regs;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0, priv_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          cpu_wr_try = 1'b0, cpu_fetch_try = 1'b0;
  logic          wr_allow, fetch_allow, viol_wr, viol_fetch;

  prot_cfg_regs dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .priv_wr(priv_wr),
    .reg_rdata(reg_rdata), .cpu_wr_try(cpu_wr_try),
    .cpu_fetch_try(cpu_fetch_try), .wr_allow(wr_allow),
    .fetch_allow(fetch_allow), .viol_wr(viol_wr), .viol_fetch(viol_fetch)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read and compares it to the returned data
  always begin
    logic seen;
    @(posedge clk);
    seen = reg_rd;
    #5;
    if (seen) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", reg_rdata, '0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(reg_rdata === it.exp, it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit p);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; priv_wr = p;
    @(negedge clk);
    reg_wr = 1'b0; priv_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_try(input bit w, input bit f, input bit ew, input bit ef, input string tag);
    @(negedge clk);
    cpu_wr_try = w; cpu_fetch_try = f;
    @(posedge clk); #5;
    check(viol_wr === ew, {tag, " viol_wr"}, DW'(viol_wr), DW'(ew));
    check(viol_fetch === ef, {tag, " viol_fetch"}, DW'(viol_fetch), DW'(ef));
    @(negedge clk);
    cpu_wr_try = 1'b0; cpu_fetch_try = 1'b0;
    @(posedge clk); #5;
    check(!viol_wr && !viol_fetch, {tag, " pulse ends"}, DW'({viol_wr, viol_fetch}), '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(wr_allow && fetch_allow, "R1 allows after reset", DW'({wr_allow, fetch_allow}), DW'(3));
    check(!viol_wr && !viol_fetch, "R1 no pulse after reset", DW'({viol_wr, viol_fetch}), '0);
    check(reg_rdata == '0, "R1 rdata after reset", reg_rdata, '0);
    do_read(4'h0, 32'h0, "R1 lock reset value");
    do_read(4'h2, 32'h0, "R1 commit reset value");
    do_read(4'h8, 32'h0, "R1 prot reset value");

    // R7 protection bits drive the allow outputs
    do_write(4'h8, 32'h3, 1'b1);
    do_read(4'h8, 32'h3, "R7 prot readback 3");
    check(!wr_allow && !fetch_allow, "R7 both blocked", DW'({wr_allow, fetch_allow}), '0);
    do_write(4'h8, 32'h1, 1'b1);
    check(wr_allow && !fetch_allow, "R7 fetch only blocked", DW'({wr_allow, fetch_allow}), DW'(2));
    do_write(4'h8, 32'h2, 1'b1);
    check(!wr_allow && fetch_allow, "R7 write only blocked", DW'({wr_allow, fetch_allow}), DW'(1));

    // R6 unprivileged write to prot ignored
    do_write(4'h8, 32'h0, 1'b0);
    do_read(4'h8, 32'h2, "R6 prot unchanged without priv");

    // R8 violation pulses
    do_try(1'b1, 1'b0, 1'b1, 1'b0, "R8 refused write");
    do_try(1'b0, 1'b1, 1'b0, 1'b0, "R8 allowed fetch");

    // R2 lock without priv, R9 upper bits zero
    do_write(4'h0, 32'hFFFF_FFFF, 1'b0);
    do_read(4'h0, 32'h1, "R2 lock set without priv, R9 upper zero");
    do_write(4'h8, 32'h0, 1'b1);
    do_read(4'h8, 32'h2, "R3 prot frozen by lock");
    do_write(4'h0, 32'h0, 1'b0);
    do_read(4'h0, 32'h0, "R2 lock cleared");
    do_write(4'h8, 32'h1, 1'b1);
    do_read(4'h8, 32'h1, "R3 prot writable after unlock");

    // R9 reserved offsets
    do_write(4'h4, 32'hFFFF_FFFF, 1'b1);
    do_read(4'h4, 32'h0, "R9 reserved 0x4 reads 0");
    do_read(4'h8, 32'h1, "R9 reserved write left prot alone");
    do_read(4'hF, 32'h0, "R9 reserved 0xF reads 0");

    // R10 idle cycle after a read returns 0
    @(posedge clk); #5;
    check(reg_rdata == '0, "R10 rdata idle", reg_rdata, '0);

    // R4 / R6 commit
    do_write(4'h2, 32'h1, 1'b0);
    do_read(4'h2, 32'h0, "R6 commit needs priv");
    do_write(4'h2, 32'h0, 1'b1);
    do_read(4'h2, 32'h0, "R4 writing 0 to commit no effect");
    do_write(4'h2, 32'hFFFF_FFFF, 1'b1);
    do_read(4'h2, 32'h1, "R4 commit set");
    do_write(4'h2, 32'h0, 1'b1);
    do_read(4'h2, 32'h1, "R4 commit sticky");
    do_write(4'h2, 32'h1, 1'b1);
    do_read(4'h2, 32'h1, "R4 second set no effect");

    // R5 commit freezes prot regardless of lock
    do_write(4'h8, 32'h2, 1'b1);
    do_read(4'h8, 32'h1, "R5 prot frozen by commit");
    do_write(4'h0, 32'h1, 1'b0);
    do_write(4'h0, 32'h0, 1'b0);
    do_write(4'h8, 32'h3, 1'b1);
    do_read(4'h8, 32'h1, "R5 frozen after lock toggle");

    // R8 simultaneous attempts
    do_try(1'b1, 1'b1, 1'b0, 1'b1, "R8 both tried, fetch refused");

    // R4 reset releases commit
    do_reset();
    do_read(4'h2, 32'h0, "R4 commit cleared by reset");
    do_read(4'h8, 32'h0, "R1 prot cleared by reset");
    do_write(4'h8, 32'h3, 1'b1);
    do_read(4'h8, 32'h3, "R3 prot writable after reset");
    do_try(1'b1, 1'b1, 1'b1, 1'b1, "R8 both refused");

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", DW'(sb_q.size()), '0);
    finish_run();
  end
endmodule